// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM. Reads and writes can be issued on consecutive clock cycles in any mix, and no idle cycle is ever needed when the data bus changes direction. The rising clock edge samples the command, address and byte-lane enables. In a write, the data follows its command by a fixed number of edges. In a read, the data comes back after a fixed latency. Both numbers depend on a static mode pin. In flow-through mode a read returns data right after the edge that takes its address, and write data comes one edge after its command. In pipelined mode the read data passes through one more register stage, and write data comes two edges after its command.

Writes that are waiting for their data are held in a short stage pipeline. A read to an address whose write is due in the same edge returns the byte-merged word. Three chip selects, a clock-enable hold, a sleep input and an asynchronous output enable complete the control set. The data bus is split into separate input and output halves. A drive flag marks the cycles in which the output carries read data. There is no flow control at the edges: timing is fixed by the mode, and the host must present write data on the edge the mode dictates.

Top module: `lw_sram`

## Requirements
- R1: In flow-through mode (`mode_pipe`=0), a read is a command with `clk_en`=1, all three `cs` bits high, `sleep`=0 and `wr`=0. The word at `addr` appears on `rdata` with `bus_drive`=1 from the edge that takes the read until the next edge with `clk_en`=1.
- R2: In pipelined mode (`mode_pipe`=1), the read data and `bus_drive`=1 appear after the second advancing edge (an edge with `clk_en`=1) that counts the command edge as the first.
- R3: Write data on `wdata` is taken at the first advancing edge after the write command in flow-through mode, and at the second in pipelined mode. Data on `wdata` at any other edge has no effect.
- R4: Reads and writes may follow each other on every advancing edge with no idle cycle. `bus_drive` is high only in cycles that carry read data, and never after a write or a no-op.
- R5: The byte lanes are 9 bits wide. Lane i is `wdata[9i+8:9i]`, and it is written only when `lane_we[i]`=1, sampled with the command. Any subset of lanes, including none or all, may be written.
- R6: If any `cs` bit is low at an advancing edge, the command is a no-op: it neither reads nor writes.
- R7: An edge with `clk_en`=0 is a hold. No stage, array word or output changes, and pending operations do not advance.
- R8: `oe`=0 forces `rdata` to zero and `bus_drive` low at once, without waiting for a clock. When `oe` returns high, the word held for output reappears.
- R9: While `sleep`=1, new commands are ignored as no-ops. Operations already in flight still complete.
- R10: A read whose output is loaded on the same edge that commits a pending write to the same address returns the byte-merged result of that write.
- R11: After reset, `bus_drive` is low and no operation is pending. `mode_pipe` may change only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| mode_pipe | input | 1 | 1 = pipelined, 0 = flow-through; static |
| clk_en | input | 1 | 1 = edge advances, 0 = hold |
| cs | input | 3 | Three active-high chip selects |
| sleep | input | 1 | Active-high power-down; blocks new commands |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| lane_we | input | LANES | Per-lane write enables |
| wdata | input | LANES*9 | Late write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | LANES*9 | Read data, zero when not driven |
| bus_drive | output | 1 | High when `rdata` carries read data |

## Verification
On every cycle the assertions check the following. The output gate follows `oe`. A hold freezes the output. In flow-through mode, deselect and sleep cycles never lead to a drive cycle, while reads always lead to one in the next cycle. In pipelined mode, a read leads to a drive cycle two advancing edges later. The data values can only be shown by the bench scenarios, which track their own model of the array. These values are: late-write capture at the right edge, partial lane merges, forwarding of a same-edge commit into a read, and the proof that ignored commands left memory untouched.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_decode.sv
module lw_sram_decode
  import lw_sram_pkg::*;
#(
  parameter int CS_N = 3
) (
  input  logic [CS_N-1:0] cs,
  input  logic            sleep,
  input  logic            wr,
  output op_e             op
);
  always_comb begin
    if (!(&cs) || sleep) op = OP_NONE;
    else if (wr)         op = OP_WRITE;
    else                 op = OP_READ;
  end
endmodule

// File: rtl/lw_sram_stages.sv
module lw_sram_stages
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              mode_pipe,
  input  op_e               new_op,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [LANES-1:0]  new_lanes,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cm_hit,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [LANES-1:0]  cm_lanes
);
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_lanes, s2_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_NONE;
      s2_op    <= OP_NONE;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s1_lanes <= '0;
      s2_lanes <= '0;
    end else if (adv) begin
      s1_op    <= new_op;
      s1_addr  <= new_addr;
      s1_lanes <= new_lanes;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  // flow-through: read from the incoming command, commit from stage 1
  // pipelined:    read from stage 1, commit from stage 2
  always_comb begin
    if (mode_pipe) begin
      rd_hit   = (s1_op == OP_READ);
      rd_addr  = s1_addr;
      cm_hit   = (s2_op == OP_WRITE);
      cm_addr  = s2_addr;
      cm_lanes = s2_lanes;
    end else begin
      rd_hit   = (new_op == OP_READ);
      rd_addr  = new_addr;
      cm_hit   = (s1_op == OP_WRITE);
      cm_addr  = s1_addr;
      cm_lanes = s1_lanes;
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    cm_hit,
  input  logic [ADDR_W-1:0]       cm_addr,
  input  logic [LANES-1:0]        cm_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_hit,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] out_q,
  output logic                    drv_q
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] old_word, merged, rd_word;

  assign old_word = mem[cm_addr];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = cm_lanes[i] ? wdata[i*LANE_W +: LANE_W]
                                                    : old_word[i*LANE_W +: LANE_W];
  end

  // same-edge commit forwarded into the read
  assign rd_word = (cm_hit && cm_addr == rd_addr) ? merged : mem[rd_addr];

  always_ff @(posedge clk) begin
    if (adv && cm_hit) mem[cm_addr] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      drv_q <= 1'b0;
    end else if (adv) begin
      drv_q <= rd_hit;
      if (rd_hit) out_q <= rd_word;
    end
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_pipe,
  input  logic                    clk_en,
  input  logic [2:0]              cs,
  input  logic                    sleep,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    bus_drive
);
  localparam int DW = LANES * LANE_W;

  op_e               cmd_op;
  logic              rd_hit, cm_hit, drv_q;
  logic [ADDR_W-1:0] rd_addr, cm_addr;
  logic [LANES-1:0]  cm_lanes;
  logic [DW-1:0]     out_q;

  lw_sram_decode #(.CS_N(3)) u_dec (
    .cs(cs), .sleep(sleep), .wr(wr), .op(cmd_op)
  );

  lw_sram_stages #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stg (
    .clk(clk), .rst_n(rst_n), .adv(clk_en), .mode_pipe(mode_pipe),
    .new_op(cmd_op), .new_addr(addr), .new_lanes(lane_we),
    .rd_hit(rd_hit), .rd_addr(rd_addr),
    .cm_hit(cm_hit), .cm_addr(cm_addr), .cm_lanes(cm_lanes)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .adv(clk_en),
    .cm_hit(cm_hit), .cm_addr(cm_addr), .cm_lanes(cm_lanes), .wdata(wdata),
    .rd_hit(rd_hit), .rd_addr(rd_addr),
    .out_q(out_q), .drv_q(drv_q)
  );

  assign bus_drive = drv_q & oe;
  assign rdata     = bus_drive ? out_q : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_pipe,
  input logic          clk_en,
  input logic [2:0]    cs,
  input logic          sleep,
  input logic          wr,
  input logic          oe,
  input logic [DW-1:0] rdata,
  input logic          bus_drive
);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!bus_drive && rdata == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && oe) |=> (!oe || ($stable(rdata) && $stable(bus_drive))));

  // R6
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !mode_pipe && !(&cs)) |=> !bus_drive);

  // R9
  sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !mode_pipe && sleep) |=> !bus_drive);

  // R1
  flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !mode_pipe && (&cs) && !sleep && !wr) |=> (bus_drive || !oe));

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !mode_pipe && (&cs) && !sleep && wr) |=> !bus_drive);

  // R2
  pipe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && mode_pipe && (&cs) && !sleep && !wr) ##1 clk_en |=> (bus_drive || !oe));
endmodule

bind lw_sram lw_sram_chk #(.DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .clk_en(clk_en),
  .cs(cs), .sleep(sleep), .wr(wr), .oe(oe), .rdata(rdata), .bus_drive(bus_drive)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_pipe = 1'b0;
  logic          clk_en = 1'b0;
  logic [2:0]    cs = 3'b000;
  logic          sleep = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] lane_we = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe = 1'b1;
  logic [DW-1:0] rdata;
  logic          bus_drive;

  lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .clk_en(clk_en),
    .cs(cs), .sleep(sleep), .wr(wr), .addr(addr), .lane_we(lane_we),
    .wdata(wdata), .oe(oe), .rdata(rdata), .bus_drive(bus_drive)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  string cur_tag = "R11";

  logic [DW-1:0] ref_mem [DEPTH];
  logic          wv [4];
  logic [AW-1:0] wa [4];
  logic [LN-1:0] wl [4];
  logic          rv [4];
  logic [AW-1:0] ra [4];
  int            ecount = 0;
  logic          exp_drv = 1'b0;
  logic [DW-1:0] exp_data = '0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                         input logic [DW-1:0] nw,
                                         input logic [LN-1:0] ln);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LN; i++)
      if (ln[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, expv);
    end
  endtask

  // one clock cycle; called just after a falling edge
  task automatic cyc(input logic en, input logic [2:0] c, input logic w,
                     input logic [AW-1:0] a, input logic [LN-1:0] l,
                     input logic o, input logic s);
    logic [63:0] rnd;
    int slot;
    rnd = {$urandom(), $urandom()};
    slot = ecount % 4;
    clk_en = en; cs = c; wr = w; addr = a; lane_we = l; oe = o; sleep = s;
    wdata = rnd[DW-1:0];
    if (en && (&c) && !s) begin
      if (w) begin
        wv[(ecount + (mode_pipe ? 2 : 1)) % 4] = 1'b1;
        wa[(ecount + (mode_pipe ? 2 : 1)) % 4] = a;
        wl[(ecount + (mode_pipe ? 2 : 1)) % 4] = l;
      end else begin
        rv[(ecount + (mode_pipe ? 1 : 0)) % 4] = 1'b1;
        ra[(ecount + (mode_pipe ? 1 : 0)) % 4] = a;
      end
    end
    @(posedge clk);
    if (en) begin
      if (wv[slot]) begin
        ref_mem[wa[slot]] = merge(ref_mem[wa[slot]], wdata, wl[slot]);
        wv[slot] = 1'b0;
      end
      if (rv[slot]) begin
        exp_drv = 1'b1;
        exp_data = ref_mem[ra[slot]];
        rv[slot] = 1'b0;
      end else begin
        exp_drv = 1'b0;
      end
      ecount++;
    end
    @(negedge clk);
    if (oe) begin
      chk(bus_drive == exp_drv, "drive", {35'd0, bus_drive}, {35'd0, exp_drv});
      if (exp_drv) chk(rdata == exp_data, "data", rdata, exp_data);
    end else begin
      chk(!bus_drive && rdata == '0, "oe-off", rdata, '0);
    end
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 3'b111, 1'b0, '0, '0, 1'b1, 1'b1);
  endtask

  task automatic wrt(input logic [AW-1:0] a, input logic [LN-1:0] l);
    cyc(1'b1, 3'b111, 1'b1, a, l, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(1'b1, 3'b111, 1'b0, a, '0, 1'b1, 1'b0);
  endtask

  task automatic do_reset(input logic pipe);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pipe = pipe;
    clk_en = 1'b0;
    for (int i = 0; i < 4; i++) begin wv[i] = 1'b0; rv[i] = 1'b0; end
    exp_drv = 1'b0;
    ecount = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R11";
    chk(!bus_drive, "after reset", {35'd0, bus_drive}, '0);
  endtask

  task automatic scenario();
    // back-to-back mix
    cur_tag = "R4";
    wrt(6'd10, 4'hF); rd(6'd11); wrt(6'd12, 4'hF); rd(6'd10); rd(6'd12); wrt(6'd11, 4'hF);
    nop(3);
    // partial lanes, including none
    cur_tag = "R5";
    wrt(6'd5, 4'b0101); wrt(6'd5, 4'b0000); wrt(6'd6, 4'b1000);
    nop(2); rd(6'd5); rd(6'd6); nop(2);
    // forwarding of a commit into a read on the same edge
    cur_tag = "R10";
    wrt(6'd9, 4'b0011); rd(6'd9); rd(6'd9); wrt(6'd9, 4'b1100); rd(6'd9); nop(3);
    // deselects: ignored writes and reads
    cur_tag = "R6";
    cyc(1'b1, 3'b110, 1'b1, 6'd3, 4'hF, 1'b1, 1'b0);
    cyc(1'b1, 3'b101, 1'b1, 6'd3, 4'hF, 1'b1, 1'b0);
    cyc(1'b1, 3'b011, 1'b0, 6'd3, 4'h0, 1'b1, 1'b0);
    nop(3); rd(6'd3); nop(2);
    // sleep ignores new commands
    cur_tag = "R9";
    wrt(6'd4, 4'hF);
    cyc(1'b1, 3'b111, 1'b1, 6'd4, 4'hF, 1'b1, 1'b1);
    cyc(1'b1, 3'b111, 1'b0, 6'd4, 4'h0, 1'b1, 1'b1);
    nop(3); rd(6'd4); nop(2);
    // hold freezes output and pending write
    cur_tag = "R7";
    rd(6'd7); wrt(6'd8, 4'hF);
    cyc(1'b0, 3'b111, 1'b0, 6'd1, 4'hF, 1'b1, 1'b0);
    cyc(1'b0, 3'b111, 1'b1, 6'd8, 4'hF, 1'b1, 1'b0);
    nop(3); rd(6'd8); nop(2);
    // asynchronous output enable
    cur_tag = "R8";
    rd(6'd20); if (mode_pipe) nop(1);
    cyc(1'b0, 3'b000, 1'b0, '0, '0, 1'b0, 1'b0);
    cyc(1'b0, 3'b000, 1'b0, '0, '0, 1'b1, 1'b0);
    nop(2);
    // constrained random mix over a narrow address range
    cur_tag = "R3";
    for (int i = 0; i < 400; i++) begin
      logic en, o, s, w;
      logic [2:0] c;
      en = ($urandom_range(0, 9) != 0);
      o  = ($urandom_range(0, 9) != 0);
      s  = ($urandom_range(0, 19) == 0);
      c  = ($urandom_range(0, 7) == 0) ? 3'($urandom()) : 3'b111;
      w  = $urandom_range(0, 1) == 1;
      cyc(en, c, w, 6'($urandom_range(0, 7)), 4'($urandom()), o, s);
    end
    nop(3);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    do_reset(1'b0);
    // flow-through mode: fill all words, then read back
    cur_tag = "R3";
    for (int i = 0; i < DEPTH; i++) wrt(AW'(i), 4'hF);
    nop(2);
    cur_tag = "R1";
    for (int i = 0; i < 8; i++) rd(AW'(i));
    nop(2);
    scenario();
    // pipelined mode
    do_reset(1'b1);
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) rd(AW'(i + 30));
    wrt(6'd31, 4'hF); rd(6'd30); rd(6'd31); nop(3);
    scenario();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule